// File: doc/BRIEF.md
# Bus DMA Handoff Arbiter

This block hands a shared processor bus from the internal processor to an external bus master. The external master raises a request. The arbiter stops that master at once by pulling its ready line low. It then watches the processor clock phase (phi2), the bus-available line from the video controller (BA) and the internal processor's read/write line (R/W). All three are asynchronous to the arbiter and pass through two-flop synchronizers clocked by a fast system clock.

The handoff is safe only when phi2, BA and R/W are all high in the same sample. The internal processor ignores a halt during write cycles, so the arbiter then counts further phi2 rising edges that fall in read cycles. When the count is complete, it drives the active-low DMA line low and keeps it low. After that, the external master's ready follows BA and phi2, so the master runs only in cycles the video controller leaves free. When the request is withdrawn, ready drops first, and DMA goes high again on the next phi2 falling edge.

Top module: `dma_handoff_arb`

## Requirements
- R1: After reset, `ext_rdy` is 1 and `dma_n` is 1.
- R2: While `dma_n` is 1, a high `dma_req` drives `ext_rdy` to 0 in the same cycle, through a combinational path.
- R3: Counting starts only on a synchronized sample in which phi2, BA and R/W are all 1. While BA stays 0, or R/W stays 0, `dma_n` stays 1.
- R4: A phi2 rising edge seen while R/W is 0 (a write cycle) neither advances nor clears the count.
- R5: `dma_n` goes to 0 on the `CNT_TARGET`-th (default 3) phi2 rising edge after the qualifying sample. Only edges with BA and R/W both 1 are counted.
- R6: If BA goes to 0 before the count completes, the count is cleared and counting waits for a new qualifying sample. `dma_n` stays 1.
- R7: Once `dma_n` is 0, it stays 0 while `dma_req` is held, whatever phi2, BA and R/W do.
- R8: While granted and requested, `ext_rdy` equals synchronized BA AND synchronized phi2.
- R9: When `dma_req` falls after the grant, `ext_rdy` goes to 0 on the next clock. `dma_n` returns to 1 only after the next synchronized phi2 falling edge. Both then rest at 1.
- R10: If `dma_req` is withdrawn before the grant, the arbiter returns to rest with `ext_rdy` 1 and `dma_n` never having gone to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dma_req | input | 1 | Bus request from the external master |
| phi2_in | input | 1 | Processor clock phase, asynchronous |
| ba_in | input | 1 | Bus-available line from the video controller, asynchronous |
| rw_in | input | 1 | Internal processor R/W line (1 = read), asynchronous |
| ext_rdy | output | 1 | Ready line to the external master |
| dma_n | output | 1 | Active-low halt line to the internal processor |

## Verification
The bench first holds BA low and then runs write-only cycles. A design that granted on a partial match would pull `dma_n` low here.

It then interrupts the count in two ways:
- A BA drop in mid-count. A design that only pauses would grant one cycle too early.
- A run of write cycles in mid-count. A design that restarts on writes would grant late, and one that counts writes would grant early.

After the grant, it toggles R/W, BA and phi2 to catch a DMA line that is not latched. It also checks that ready stays off in phases the video controller owns.

Finally, it withdraws the request both before and after the grant. A design that released DMA before phi2 fell, or that left ready low at rest, would fail.

// File: rtl/dma_handoff_arb.sv
module dma_handoff_arb #(
  parameter int CNT_TARGET = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dma_req,
  input  logic phi2_in,
  input  logic ba_in,
  input  logic rw_in,
  output logic ext_rdy,
  output logic dma_n
);
  localparam int CW = $clog2(CNT_TARGET + 1);

  typedef enum logic [2:0] {IDLE, HOLD_EXT, QUALIFY, GRANTED, RELEASE} st_t;
  st_t state;

  logic [SYNC_STAGES-1:0] phi2_sy, ba_sy, rw_sy;
  logic phi2_s, ba_s, rw_s, phi2_d;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phi2_sy <= '0;
      ba_sy   <= '0;
      rw_sy   <= '0;
      phi2_d  <= 1'b0;
    end else begin
      phi2_sy <= {phi2_sy[SYNC_STAGES-2:0], phi2_in};
      ba_sy   <= {ba_sy[SYNC_STAGES-2:0], ba_in};
      rw_sy   <= {rw_sy[SYNC_STAGES-2:0], rw_in};
      phi2_d  <= phi2_s;
    end

  assign phi2_s = phi2_sy[SYNC_STAGES-1];
  assign ba_s   = ba_sy[SYNC_STAGES-1];
  assign rw_s   = rw_sy[SYNC_STAGES-1];

  wire phi2_rise = phi2_s & ~phi2_d;
  wire phi2_fall = ~phi2_s & phi2_d;
  wire qual      = phi2_s & ba_s & rw_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        IDLE: if (dma_req) state <= HOLD_EXT;
        HOLD_EXT: begin
          cnt <= '0;
          if (!dma_req) state <= IDLE;
          else if (qual) state <= QUALIFY;
        end
        QUALIFY: begin
          if (!dma_req) begin
            state <= IDLE;
            cnt   <= '0;
          end else if (!ba_s) begin
            state <= HOLD_EXT;
            cnt   <= '0;
          end else if (phi2_rise && rw_s) begin
            if (cnt == CW'(CNT_TARGET - 1)) state <= GRANTED;
            else cnt <= cnt + 1'b1;
          end
        end
        GRANTED: if (!dma_req) state <= RELEASE;
        RELEASE: if (phi2_fall) state <= IDLE;
        default: state <= IDLE;
      endcase
    end

  assign dma_n   = !(state == GRANTED || state == RELEASE);
  assign ext_rdy = (state == IDLE && !dma_req) ||
                   (state == GRANTED && dma_req && ba_s && phi2_s);
endmodule

module dma_handoff_arb_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dma_req,
  input logic       ext_rdy,
  input logic       dma_n,
  input logic       phi2_s,
  input logic       phi2_d,
  input logic       ba_s,
  input logic       rw_s,
  input logic [2:0] state
);
  a_r2_hold_on_req: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_n && dma_req) |-> !ext_rdy);
  a_r3_grant_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dma_n) |-> $past(ba_s && rw_s && phi2_s));
  a_r7_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd3 && dma_req) |=> !dma_n);
  a_r8_rdy_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_rdy && !dma_n) |-> (ba_s && phi2_s && dma_req));
  a_r9_release_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_n) |-> $past(phi2_d && !phi2_s));
endmodule

bind dma_handoff_arb dma_handoff_arb_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dma_req(dma_req), .ext_rdy(ext_rdy),
  .dma_n(dma_n), .phi2_s(phi2_s), .phi2_d(phi2_d), .ba_s(ba_s),
  .rw_s(rw_s), .state(state)
);

// File: tb/sim_dma_handoff_arb.sv
module sim_dma_handoff_arb;
  logic clk = 0, rst_n = 0, dma_req = 0, phi2_in = 0, ba_in = 0, rw_in = 1;
  logic ext_rdy, dma_n;
  int checks = 0, fails = 0;

  dma_handoff_arb u0 (.clk(clk), .rst_n(rst_n), .dma_req(dma_req),
    .phi2_in(phi2_in), .ba_in(ba_in), .rw_in(rw_in),
    .ext_rdy(ext_rdy), .dma_n(dma_n));

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic cyc(input logic ba, input logic rw);
    @(negedge clk);
    ba_in = ba; rw_in = rw; phi2_in = 0;
    repeat (8) @(negedge clk);
    phi2_in = 1;
    repeat (8) @(negedge clk);
  endtask

  task automatic release_bus();
    dma_req = 0;
    @(negedge clk);
    chk("R9 rdy drops", ext_rdy, 0);
    chk("R9 dma held", dma_n, 0);
    phi2_in = 0;
    repeat (5) @(negedge clk);
    chk("R9 dma released", dma_n, 1);
    chk("R9 rdy rest", ext_rdy, 1);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 rdy", ext_rdy, 1);
    chk("R1 dma", dma_n, 1);
  endtask

  task automatic t_request_and_block();
    dma_req = 1; #1;
    chk("R2 rdy low", ext_rdy, 0);
    repeat (3) cyc(0, 1);
    chk("R3 ba low", dma_n, 1);
    repeat (3) cyc(1, 0);
    chk("R3 writes", dma_n, 1);
  endtask

  task automatic t_basic_grant();
    repeat (3) cyc(1, 1);
    chk("R5 not yet", dma_n, 1);
    cyc(1, 1);
    chk("R5 granted", dma_n, 0);
    chk("R8 rdy on", ext_rdy, 1);
  endtask

  task automatic t_latched();
    cyc(1, 0);
    chk("R7 write", dma_n, 0);
    cyc(0, 1);
    chk("R8 ba low", ext_rdy, 0);
    chk("R7 ba low", dma_n, 0);
    @(negedge clk); phi2_in = 0;
    repeat (4) @(negedge clk);
    chk("R8 phi2 low", ext_rdy, 0);
    chk("R7 phi2 low", dma_n, 0);
    cyc(1, 1);
    chk("R8 rdy back", ext_rdy, 1);
  endtask

  task automatic t_ba_restart();
    dma_req = 1;
    cyc(1, 1); cyc(1, 1); cyc(0, 1);
    cyc(1, 1); cyc(1, 1); cyc(1, 1);
    chk("R6 restarted", dma_n, 1);
    cyc(1, 1);
    chk("R6 granted", dma_n, 0);
    release_bus();
  endtask

  task automatic t_write_hold();
    dma_req = 1;
    cyc(1, 1); cyc(1, 1); cyc(1, 1);
    repeat (3) cyc(1, 0);
    chk("R4 held", dma_n, 1);
    cyc(1, 1);
    chk("R4 granted", dma_n, 0);
    release_bus();
  endtask

  task automatic t_withdraw();
    dma_req = 1;
    cyc(1, 1); cyc(1, 1);
    dma_req = 0;
    repeat (2) @(negedge clk);
    chk("R10 rdy", ext_rdy, 1);
    chk("R10 dma", dma_n, 1);
    cyc(1, 1); cyc(1, 1);
    chk("R10 stays", dma_n, 1);
  endtask

  initial begin
    t_reset();
    t_request_and_block();
    t_basic_grant();
    t_latched();
    release_bus();
    t_ba_restart();
    t_write_hold();
    t_withdraw();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule